// File: doc/BRIEF.md
# FIFO Threshold Offset Loader

This block supplies the two threshold offsets that a FIFO uses to raise its almost-empty and almost-full flags. While master reset is held, it latches a three-bit method select and a parity-layout select. The method select either fixes both offsets to one of five preset values, or leaves them at zero to be programmed after reset. Programming goes through one of two paths: two write strobes on the wide data port, or 22 bits clocked in one at a time on a serial pin.

Once both offsets hold their final values, a done flag rises. From then on the offsets are frozen until the next master reset. A partial reset (flush) is meant for clearing the FIFO storage. Here it keeps the offsets, the done flag and the latched method, and it blocks any programming during the cycles it is held. The FIFO storage and its flag logic are outside this block.

Top module: `fifo_thresh_loader`

## Requirements
- R1: The method select `mode_sel` and the parity select `parity_sel` are captured on every clock edge where `rst_n` is low. Changes on them after `rst_n` goes high have no effect.
- R2: Preset codes are 3'b010=8, 3'b011=16, 3'b100=64, 3'b101=256 and 3'b110=1024. With a preset code, both offsets equal that value and `cfg_done` is high from the first edge taken in reset.
- R3: Codes 3'b001 and 3'b111 select the parallel method. The first accepted `wr_strobe` loads `ae_offset` and the second loads `af_offset`. Each takes effect at the edge that samples the strobe, and `cfg_done` rises with the second.
- R4: With `parity_sel` high at reset, a parallel word gives offset = {wr_data[11:9], wr_data[7:0]}, so bit 8 is skipped. With `parity_sel` low, the offset is wr_data[10:0].
- R5: Code 3'b000 selects the serial method. Each edge with `ser_en` high shifts in `ser_din`: 11 bits of the almost-empty offset MSB first, then 11 bits of the almost-full offset MSB first. Both offsets stay 0 until the 22nd bit, and at that edge both update and `cfg_done` rises.
- R6: Once `cfg_done` is high, `wr_strobe` and `ser_en` change neither offset until the next master reset.
- R7: While `flush_n` is low, the offsets, `cfg_done` and the latched method stay unchanged, and strobes or serial bits presented in those cycles are discarded.
- R8: During master reset with a programming method (codes 000, 001, 111), both offsets read 0 and `cfg_done` reads 0.
- R9: The serial input has no effect in the parallel method, and `wr_strobe` has no effect in the serial method.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low, synchronous |
| flush_n | input | 1 | Partial reset, active low |
| mode_sel | input | 3 | Method select, sampled in reset |
| parity_sel | input | 1 | Parity layout select, sampled in reset |
| wr_strobe | input | 1 | Parallel offset write strobe |
| wr_data | input | 36 | Parallel data port |
| ser_en | input | 1 | Serial shift enable |
| ser_din | input | 1 | Serial data bit |
| ae_offset | output | 11 | Almost-empty offset |
| af_offset | output | 11 | Almost-full offset |
| cfg_done | output | 1 | Both offsets loaded |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before use, so that the latched method is defined. They also assume that every control input is stable around the rising edge. The bench changes inputs only on the falling edge and holds every reset for two edges. It reads outputs one time unit after the rising edge, so each comparison sees the state that edge produced.

// File: rtl/fifo_thresh_loader.sv
module fifo_thresh_loader #(
  parameter int DATA_W  = 36,
  parameter int OFS_W   = 11,
  parameter int PAR_BIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_n,
  input  logic [2:0]        mode_sel,
  input  logic              parity_sel,
  input  logic              wr_strobe,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ser_en,
  input  logic              ser_din,
  output logic [OFS_W-1:0]  ae_offset,
  output logic [OFS_W-1:0]  af_offset,
  output logic              cfg_done
);
  localparam int SER_BITS = 2 * OFS_W;
  localparam int CNT_W    = $clog2(SER_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SER_BITS - 1);

  function automatic logic [OFS_W-1:0] preset_of(input logic [2:0] m);
    case (m)
      3'b010:  return OFS_W'(8);
      3'b011:  return OFS_W'(16);
      3'b100:  return OFS_W'(64);
      3'b101:  return OFS_W'(256);
      3'b110:  return OFS_W'(1024);
      default: return '0;
    endcase
  endfunction

  logic [2:0]          mode_q;
  logic                parity_q;
  logic                ae_loaded;
  logic [CNT_W-1:0]    bit_cnt;
  logic [SER_BITS-2:0] shreg;
  logic [OFS_W-1:0]    par_word;
  logic                is_par, is_ser, take_par, take_ser;
  logic                unused_ok;

  assign is_par   = (mode_q == 3'b001) || (mode_q == 3'b111);
  assign is_ser   = (mode_q == 3'b000);
  assign take_par = is_par && wr_strobe && flush_n && !cfg_done;
  assign take_ser = is_ser && ser_en && flush_n && !cfg_done;
  assign par_word = parity_q ? {wr_data[OFS_W:PAR_BIT+1], wr_data[PAR_BIT-1:0]}
                             : wr_data[OFS_W-1:0];
  assign unused_ok = &{1'b0, wr_data[DATA_W-1:OFS_W+1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= mode_sel;
      parity_q  <= parity_sel;
      ae_offset <= preset_of(mode_sel);
      af_offset <= preset_of(mode_sel);
      cfg_done  <= (preset_of(mode_sel) != '0);
      ae_loaded <= 1'b0;
      bit_cnt   <= '0;
      shreg     <= '0;
    end else begin
      if (take_par) begin
        if (!ae_loaded) begin
          ae_offset <= par_word;
          ae_loaded <= 1'b1;
        end else begin
          af_offset <= par_word;
          cfg_done  <= 1'b1;
        end
      end
      if (take_ser) begin
        shreg   <= {shreg[SER_BITS-3:0], ser_din};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT) begin
          ae_offset <= shreg[SER_BITS-2:OFS_W-1];
          af_offset <= {shreg[OFS_W-2:0], ser_din};
          cfg_done  <= 1'b1;
        end
      end
    end
  end
endmodule

module fifo_thresh_loader_chk #(
  parameter int OFS_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush_n,
  input logic             wr_strobe,
  input logic             ser_en,
  input logic [2:0]       mode_q,
  input logic [OFS_W-1:0] ae_offset,
  input logic [OFS_W-1:0] af_offset,
  input logic             cfg_done
);
  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> cfg_done);

  p_frozen_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done && (wr_strobe || ser_en)) |=> ($stable(ae_offset) && $stable(af_offset)));

  p_flush_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_n |=> ($stable(ae_offset) && $stable(af_offset) && $stable(cfg_done) && $stable(mode_q)));

  p_preset_equal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q inside {3'b010, 3'b011, 3'b100, 3'b101, 3'b110}) |-> (cfg_done && ae_offset == af_offset
      && $onehot0(ae_offset)));

  p_serial_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b000 && !cfg_done) |-> (ae_offset == '0 && af_offset == '0));

  p_mode_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));
endmodule

bind fifo_thresh_loader fifo_thresh_loader_chk #(.OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush_n(flush_n), .wr_strobe(wr_strobe),
  .ser_en(ser_en), .mode_q(mode_q), .ae_offset(ae_offset),
  .af_offset(af_offset), .cfg_done(cfg_done)
);

// File: tb/fifo_thresh_loader_tb_top.sv
module fifo_thresh_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 1 + 3 + 36 + 36 + 11 + 11;
  localparam logic [VW-1:0] VEC [4] = '{
    {1'b0, 3'b001, 36'h000000055, 36'h0000007FF, 11'h055, 11'h7FF},
    {1'b1, 3'b001, 36'h000000FFF, 36'h000000100, 11'h7FF, 11'h000},
    {1'b0, 3'b111, 36'hFFFFFF100, 36'h000000A00, 11'h100, 11'h200},
    {1'b1, 3'b111, 36'h000000E00, 36'h000000355, 11'h700, 11'h155}
  };

  logic clk = 0, rst_n = 0, flush_n = 1, parity_sel = 0;
  logic [2:0] mode_sel = 3'b001;
  logic wr_strobe = 0, ser_en = 0, ser_din = 0;
  logic [35:0] wr_data = '0;
  logic [10:0] ae_offset, af_offset;
  logic cfg_done;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_thresh_loader dut_i (
    .clk(clk), .rst_n(rst_n), .flush_n(flush_n), .mode_sel(mode_sel),
    .parity_sel(parity_sel), .wr_strobe(wr_strobe), .wr_data(wr_data),
    .ser_en(ser_en), .ser_din(ser_din), .ae_offset(ae_offset),
    .af_offset(af_offset), .cfg_done(cfg_done)
  );

  task automatic check(input string req, input logic [10:0] ae_e, input logic [10:0] af_e,
                       input logic done_e);
    checks++;
    if (ae_offset !== ae_e || af_offset !== af_e || cfg_done !== done_e) begin
      errors++;
      $display("FAIL %s: got ae=%0d af=%0d done=%0b, expected ae=%0d af=%0d done=%0b",
               req, ae_offset, af_offset, cfg_done, ae_e, af_e, done_e);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset(input logic [2:0] m, input logic p);
    @(negedge clk);
    rst_n = 0; mode_sel = m; parity_sel = p;
    wr_strobe = 0; ser_en = 0; flush_n = 1;
    step(); step();
    @(negedge clk);
    rst_n = 1; mode_sel = ~m; parity_sel = ~p;
  endtask

  task automatic strobe(input logic [35:0] d);
    @(negedge clk); wr_strobe = 1; wr_data = d;
    step();
    @(negedge clk); wr_strobe = 0;
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk); ser_en = 1; ser_din = b;
    step();
    @(negedge clk); ser_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [10:0] sae, saf;
    logic [21:0] stream;

    // R8: reset state in a programming method
    @(negedge clk); step(); step();
    check("R8 reset state", 11'd0, 11'd0, 1'b0);

    // R3 R4 R1: table of parallel loads (mode/parity flipped after release)
    for (int i = 0; i < 4; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      do_reset(v[96:94], v[97]);
      strobe(v[93:58]);
      check("R3 R4 first word", v[21:11], 11'd0, 1'b0);
      strobe(v[57:22]);
      check("R3 R4 R1 second word", v[21:11], v[10:0], 1'b1);
      strobe(36'h000000123);
      check("R6 strobe after done", v[21:11], v[10:0], 1'b1);
    end

    // R2: presets
    for (int k = 0; k < 5; k++) begin
      logic [10:0] pv;
      pv = (k == 0) ? 11'd8 : (k == 1) ? 11'd16 : (k == 2) ? 11'd64 : (k == 3) ? 11'd256 : 11'd1024;
      do_reset(3'(k + 2), 1'b0);
      step();
      check("R2 preset", pv, pv, 1'b1);
      strobe(36'h000000001);
      check("R2 preset ignores strobe", pv, pv, 1'b1);
    end

    // R5 R9: serial load
    sae = 11'h5A3; saf = 11'h2C7; stream = {sae, saf};
    do_reset(3'b000, 1'b0);
    strobe(36'h0000007FF);
    check("R9 strobe in serial method", 11'd0, 11'd0, 1'b0);
    for (int b = 21; b >= 1; b--) shift_bit(stream[b]);
    check("R5 before last bit", 11'd0, 11'd0, 1'b0);
    shift_bit(stream[0]);
    check("R5 after last bit", sae, saf, 1'b1);
    for (int b = 0; b < 5; b++) shift_bit(1'b1);
    check("R6 serial after done", sae, saf, 1'b1);

    // R9: serial bits in parallel method
    do_reset(3'b001, 1'b0);
    for (int b = 0; b < 22; b++) shift_bit(1'b1);
    check("R9 serial in parallel method", 11'd0, 11'd0, 1'b0);

    // R7: flush blocks programming and retains state
    @(negedge clk); flush_n = 0; wr_strobe = 1; wr_data = 36'h000000077;
    step();
    @(negedge clk); flush_n = 1; wr_strobe = 0;
    check("R7 strobe during flush", 11'd0, 11'd0, 1'b0);
    strobe(36'h000000011);
    strobe(36'h000000022);
    check("R7 load after flush", 11'h011, 11'h022, 1'b1);
    @(negedge clk); flush_n = 0;
    step(); step();
    check("R7 flush keeps offsets", 11'h011, 11'h022, 1'b1);
    @(negedge clk); flush_n = 1;

    // R7: partial serial load interrupted by flush keeps progress
    do_reset(3'b000, 1'b0);
    for (int b = 21; b >= 11; b--) shift_bit(stream[b]);
    @(negedge clk); flush_n = 0; ser_en = 1; ser_din = 1'b1;
    step();
    @(negedge clk); flush_n = 1; ser_en = 0;
    for (int b = 10; b >= 0; b--) shift_bit(stream[b]);
    check("R7 serial bit during flush dropped", sae, saf, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule